// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, every cycle, where each of the two ALU operands of the instruction in the execute stage of a five-stage in-order pipeline should come from. An operand comes from the register-file value captured when the instruction left decode, from the ALU result held in the EX/MEM pipeline register, or from the write-back value held in MEM/WB. A third decision covers store data: it picks between the store's own data value and the MEM/WB write-back value while the store sits in the memory stage. With this choice, a load result can feed the store that follows it without a bubble.

The block is purely combinational. Its inputs are the source register numbers of the execute-stage instruction and of the memory-stage store, the destination numbers and write enables of the memory and write-back stages, and flags marking the memory-stage instruction as a load or a store. Its outputs are select codes for the operand multiplexers.

Only read-after-write dependences need a bypass, because every instruction reads in decode and writes in the last stage. The register file writes early in a cycle and reads late, so decode needs no path of its own. Stall insertion is handled elsewhere.

Top module: `operand_fwd_unit`

## Requirements
- R1: With no enabled, nonzero, matching destination in EX/MEM or MEM/WB, an operand select is 2'b00 (register file).
- R2: When EX/MEM has write enable set, a nonzero destination equal to the operand's source, and is not a load, the select is 2'b10 (EX/MEM result).
- R3: When only MEM/WB has write enable set with a nonzero destination equal to the operand's source, the select is 2'b01 (MEM/WB value).
- R4: When both EX/MEM (non-load) and MEM/WB match the same source, the younger EX/MEM value wins and the select is 2'b10.
- R5: Register 0 is never bypassed: a source of 0 always selects 2'b00, and a destination of 0 never produces a bypass.
- R6: A stage whose write enable is low is never a bypass source. A disabled EX/MEM match lets an enabled MEM/WB match through with select 2'b01.
- R7: When EX/MEM holds a load whose destination matches an operand, that operand selects 2'b00, even if MEM/WB also matches, because the older value is stale. A load to a different register does not block an unrelated MEM/WB match.
- R8: Store-data select is 1 exactly when the memory-stage instruction is a store, MEM/WB write enable is set, and the MEM/WB destination is nonzero and equal to the store's data register. Otherwise it is 0.
- R9: The two ALU operands are selected independently, each by its own source register.
- R10: The sequence add r1, then a load based on r1, then a store of the loaded value based on r1, is served entirely by bypass selects. The load base takes 2'b10. The store base takes 2'b01. The store data takes the MEM/WB path one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a | input | REG_W | First source register of the execute-stage instruction |
| ex_src_b | input | REG_W | Second source register of the execute-stage instruction |
| mem_dst | input | REG_W | Destination register held in EX/MEM |
| mem_wr_en | input | 1 | EX/MEM instruction writes a register |
| mem_is_load | input | 1 | EX/MEM instruction is a load (result not yet available) |
| mem_is_store | input | 1 | EX/MEM instruction is a store |
| mem_store_src | input | REG_W | Data register of the memory-stage store |
| wb_dst | input | REG_W | Destination register held in MEM/WB |
| wb_wr_en | input | 1 | MEM/WB instruction writes a register |
| alu_sel_a | output | 2 | Mux select for ALU operand A (00 regfile, 10 EX/MEM, 01 MEM/WB) |
| alu_sel_b | output | 2 | Mux select for ALU operand B (same coding) |
| store_sel_wb | output | 1 | 1: store data taken from MEM/WB value |

## Verification
The bench targets the cases where both later stages name the same register. A design with the priority reversed would feed the ALU the older, stale value. It drives register 0 as both source and destination. A unit that ignores register 0 would bypass garbage over the hard-wired zero. A matching load in EX/MEM must block both bypass paths: a design that chose EX/MEM there would read an address in place of loaded data, and one that fell through to MEM/WB would read an outdated result. The add–load–store chain and disabled-enable cases catch gating mistakes on the store-data path and on write enables.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Operand mux select coding, shared with the datapath multiplexers.
    typedef enum logic [1:0] {
        FWD_REGFILE = 2'b00,
        FWD_MEMWB   = 2'b01,
        FWD_EXMEM   = 2'b10
    } fwd_sel_e;

    localparam int NUM_ALU_OPS = 2;

endpackage

// File: rtl/fwd_reg_match.sv
// Compares one consumer source register with one producer destination.
module fwd_reg_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst,
    input  logic             wr_en,
    output logic             hit
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    always_comb begin
        hit = wr_en && (dst != ZERO_REG) && (dst == src);
    end
endmodule

// File: rtl/fwd_operand_sel.sv
// Picks the source of a single ALU operand with younger-stage priority.
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wr_en,
    input  logic             mem_is_load,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_wr_en,
    output fwd_sel_e         sel
);
    logic mem_hit;
    logic wb_hit;

    fwd_reg_match #(.REG_W(REG_W)) mem_cmp_i (
        .src   (src),
        .dst   (mem_dst),
        .wr_en (mem_wr_en),
        .hit   (mem_hit)
    );

    fwd_reg_match #(.REG_W(REG_W)) wb_cmp_i (
        .src   (src),
        .dst   (wb_dst),
        .wr_en (wb_wr_en),
        .hit   (wb_hit)
    );

    always_comb begin
        unique case ({mem_hit, wb_hit})
            2'b10, 2'b11: sel = mem_is_load ? FWD_REGFILE : FWD_EXMEM;
            2'b01:        sel = FWD_MEMWB;
            default:      sel = FWD_REGFILE;
        endcase
    end
endmodule

// File: rtl/fwd_store_sel.sv
// Chooses whether memory-stage store data comes from the write-back value.
module fwd_store_sel #(
    parameter int REG_W = 5
) (
    input  logic             mem_is_store,
    input  logic [REG_W-1:0] mem_store_src,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_wr_en,
    output logic             sel_wb
);
    logic wb_hit;

    fwd_reg_match #(.REG_W(REG_W)) st_cmp_i (
        .src   (mem_store_src),
        .dst   (wb_dst),
        .wr_en (wb_wr_en),
        .hit   (wb_hit)
    );

    always_comb begin
        sel_wb = mem_is_store && wb_hit;
    end
endmodule

// File: rtl/operand_fwd_unit.sv
module operand_fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] ex_src_a,
    input  logic [REG_W-1:0] ex_src_b,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wr_en,
    input  logic             mem_is_load,
    input  logic             mem_is_store,
    input  logic [REG_W-1:0] mem_store_src,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_wr_en,
    output logic [1:0]       alu_sel_a,
    output logic [1:0]       alu_sel_b,
    output logic             store_sel_wb
);
    logic [REG_W-1:0] op_src [NUM_ALU_OPS];
    fwd_sel_e         op_sel [NUM_ALU_OPS];

    always_comb begin
        op_src[0] = ex_src_a;
        op_src[1] = ex_src_b;
    end

    for (genvar g = 0; g < NUM_ALU_OPS; g++) begin : g_op
        fwd_operand_sel #(.REG_W(REG_W)) op_sel_i (
            .src         (op_src[g]),
            .mem_dst     (mem_dst),
            .mem_wr_en   (mem_wr_en),
            .mem_is_load (mem_is_load),
            .wb_dst      (wb_dst),
            .wb_wr_en    (wb_wr_en),
            .sel         (op_sel[g])
        );
    end

    fwd_store_sel #(.REG_W(REG_W)) store_sel_i (
        .mem_is_store  (mem_is_store),
        .mem_store_src (mem_store_src),
        .wb_dst        (wb_dst),
        .wb_wr_en      (wb_wr_en),
        .sel_wb        (store_sel_wb)
    );

    always_comb begin
        alu_sel_a = op_sel[0];
        alu_sel_b = op_sel[1];
    end
endmodule

// File: rtl/fwd_checker.sv
module fwd_checker #(
    parameter int REG_W = 5
) (
    input logic [REG_W-1:0] ex_src_a,
    input logic [REG_W-1:0] ex_src_b,
    input logic [REG_W-1:0] mem_dst,
    input logic             mem_wr_en,
    input logic             mem_is_load,
    input logic             mem_is_store,
    input logic [REG_W-1:0] mem_store_src,
    input logic [REG_W-1:0] wb_dst,
    input logic             wb_wr_en,
    input logic [1:0]       alu_sel_a,
    input logic [1:0]       alu_sel_b,
    input logic             store_sel_wb
);
    localparam logic [REG_W-1:0] ZR = '0;

    always_comb begin
        p_single_src_r9: assert ($onehot0(alu_sel_a) && $onehot0(alu_sel_b));
        p_zero_src_r5: assert ((ex_src_a != ZR || alu_sel_a == 2'b00) &&
                               (ex_src_b != ZR || alu_sel_b == 2'b00));
        p_young_wins_r4: assert (!(mem_wr_en && !mem_is_load && mem_dst != ZR &&
                                   mem_dst == ex_src_a) || alu_sel_a == 2'b10);
        p_wb_source_r3: assert (alu_sel_a != 2'b01 ||
                                (wb_wr_en && wb_dst == ex_src_a && wb_dst != ZR));
        p_load_block_r7: assert (!(mem_wr_en && mem_is_load && mem_dst != ZR &&
                                   mem_dst == ex_src_b) || alu_sel_b == 2'b00);
        p_store_gate_r8: assert (!store_sel_wb || (mem_is_store && wb_wr_en));
    end
endmodule

bind operand_fwd_unit fwd_checker #(.REG_W(REG_W)) chk_i (
    .ex_src_a      (ex_src_a),
    .ex_src_b      (ex_src_b),
    .mem_dst       (mem_dst),
    .mem_wr_en     (mem_wr_en),
    .mem_is_load   (mem_is_load),
    .mem_is_store  (mem_is_store),
    .mem_store_src (mem_store_src),
    .wb_dst        (wb_dst),
    .wb_wr_en      (wb_wr_en),
    .alu_sel_a     (alu_sel_a),
    .alu_sel_b     (alu_sel_b),
    .store_sel_wb  (store_sel_wb)
);

// File: tb/operand_fwd_unit_tb_top.sv
module operand_fwd_unit_tb_top;
    localparam int RW = 5;

    typedef struct {
        logic [1:0] a;
        logic [1:0] b;
        logic       s;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [RW-1:0] ex_src_a = '0, ex_src_b = '0, mem_dst = '0, mem_store_src = '0, wb_dst = '0;
    logic mem_wr_en = 0, mem_is_load = 0, mem_is_store = 0, wb_wr_en = 0;
    logic [1:0] alu_sel_a, alu_sel_b;
    logic store_sel_wb;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;
    exp_t exp_q[$];

    operand_fwd_unit #(.REG_W(RW)) dut_i (
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .mem_dst(mem_dst),
        .mem_wr_en(mem_wr_en), .mem_is_load(mem_is_load), .mem_is_store(mem_is_store),
        .mem_store_src(mem_store_src), .wb_dst(wb_dst), .wb_wr_en(wb_wr_en),
        .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b), .store_sel_wb(store_sel_wb)
    );

    task automatic drive(input int ra, input int rb, input int md, input bit mwe,
                         input bit mld, input bit mst, input int msrc, input int wd,
                         input bit wwe, input logic [1:0] ea, input logic [1:0] eb,
                         input bit es, input string tag);
        exp_t e;
        @(posedge clk);
        ex_src_a = RW'(ra); ex_src_b = RW'(rb); mem_dst = RW'(md);
        mem_wr_en = mwe; mem_is_load = mld; mem_is_store = mst;
        mem_store_src = RW'(msrc); wb_dst = RW'(wd); wb_wr_en = wwe;
        e.a = ea; e.b = eb; e.s = es; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare results at the falling edge, away from input changes.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_tests++;
            if (alu_sel_a !== e.a || alu_sel_b !== e.b || store_sel_wb !== e.s) begin
                n_fail++;
                $display("FAIL %s: got a=%b b=%b s=%b expected a=%b b=%b s=%b",
                         e.tag, alu_sel_a, alu_sel_b, store_sel_wb, e.a, e.b, e.s);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        //     ra rb md mwe ld st msrc wd wwe  a      b      s
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 0, "R1 reset idle");
        drive(3, 4, 7, 1, 0, 0, 0, 8, 1, 2'b00, 2'b00, 0, "R1 no match");
        drive(5, 1, 5, 1, 0, 0, 0, 0, 0, 2'b10, 2'b00, 0, "R2 exmem bypass");
        drive(1, 6, 0, 0, 0, 0, 0, 6, 1, 2'b00, 2'b01, 0, "R3 memwb bypass");
        drive(9, 9, 9, 1, 0, 0, 0, 9, 1, 2'b10, 2'b10, 0, "R4 younger wins");
        drive(0, 0, 0, 1, 0, 0, 0, 0, 1, 2'b00, 2'b00, 0, "R5 reg zero");
        drive(11, 2, 11, 0, 0, 0, 0, 11, 0, 2'b00, 2'b00, 0, "R6 both disabled");
        drive(11, 2, 11, 0, 0, 0, 0, 11, 1, 2'b01, 2'b00, 0, "R6 disabled exmem");
        drive(12, 12, 12, 1, 1, 0, 0, 12, 1, 2'b00, 2'b00, 0, "R7 load blocks");
        drive(14, 13, 13, 1, 1, 0, 0, 14, 1, 2'b01, 2'b00, 0, "R7 unrelated load");
        drive(0, 0, 0, 0, 0, 1, 4, 4, 1, 2'b00, 2'b00, 1, "R8 store data bypass");
        drive(0, 0, 0, 0, 0, 1, 4, 4, 0, 2'b00, 2'b00, 0, "R8 wb disabled");
        drive(0, 0, 0, 0, 0, 1, 0, 0, 1, 2'b00, 2'b00, 0, "R5 R8 store zero reg");
        drive(0, 0, 0, 0, 0, 0, 4, 4, 1, 2'b00, 2'b00, 0, "R8 not a store");
        drive(2, 3, 2, 1, 0, 0, 0, 3, 1, 2'b10, 2'b01, 0, "R9 independent");
        // R10 add r1 / lw r4,0(r1) / sw r4,12(r1)
        drive(1, 0, 1, 1, 0, 0, 0, 0, 0, 2'b10, 2'b00, 0, "R10 load base");
        drive(1, 4, 4, 1, 1, 0, 0, 1, 1, 2'b01, 2'b00, 0, "R10 store base");
        drive(0, 0, 0, 0, 0, 1, 4, 4, 1, 2'b00, 2'b00, 1, "R10 store data");
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule